// File: doc/BRIEF.md
# Display-Side Link Receiver with Read Turnaround

This block sits at the display end of a low-pin-count link. Frames arrive as a bit stream on the system clock. The block decodes each frame and then drives the display's parallel port. A write frame puts data and control on the port and then pulses one of two word clocks low, so a main display and a sub-display can share the link. A read frame drives control and releases the data bus. The block then creates its own word-clock pulse and latches the display's answer on the rising edge of that pulse. It sends only the data bits back over a return serial line.

A third frame kind rebuilds a write-only serial display interface. The serial data bit and a regenerated serial clock each appear on two pins, so a display can use either wiring. Chip select is carried on the first word clock. Frames with an unknown type code are dropped and counted.

Top module: `disp_link_slave`

## Requirements
- R1: After reset both word clocks are high, the data bus is released (dp_oe=0), dp_out, cntl_out and rw_out are zero, tx_en is low and err_cnt is zero.
- R2: A frame is FRAME_W=28 bits, shifted in least significant bit first, one per cycle while rx_en is high. Bits [1:0] hold the type (0 write, 1 read, 2 serial-display, 3 illegal). Bit 2 selects the channel (0 = wclk0, 1 = wclk1). Bit 3 is the chip-select level. Bits [9:4] hold control and bits [27:10] hold data. If rx_en drops before all 28 bits arrive, the partial frame is discarded.
- R3: For a write, dp_out, cntl_out, rw_out=0 and dp_oe=1 are valid for at least one cycle before the selected word clock falls, and they stay stable while it is low. The clock stays low for WR_LOW=3 cycles. The other word clock stays high.
- R4: For a read, cntl_out and rw_out=1 are driven and dp_oe is 0 for at least one idle cycle before the selected word clock falls. The clock stays low for RD_LOW=4 cycles. The other word clock stays high.
- R5: For a read, dp_in as seen in the last low cycle of the word clock is captured at its rising edge. It is returned on tx_dat, least significant bit first, during 18 consecutive cycles with tx_en high. The word clocks stay high and dp_oe stays 0 while tx_en is high.
- R6: For a serial-display frame, the serial data bit (frame control bit 4) is driven on both dp_out[7] and cntl_out[4]. The regenerated serial clock, idle high and low for SPI_LOW=2 cycles, is driven on both dp_out[6] and cntl_out[5]. cntl_out[3:0] take the frame's control bits [3:0]. wclk0 takes the chip-select bit and holds it until the next accepted frame. wclk1 stays high.
- R7: A frame of type 3 increments err_cnt by one and changes no port output.
- R8: Between frames dp_out, cntl_out and rw_out keep the last values driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Inbound frame bit valid |
| rx_dat | input | 1 | Inbound frame bit |
| dp_in | input | 18 | Data bus value read from the display |
| dp_out | output | 18 | Data bus value driven to the display |
| dp_oe | output | 1 | Data bus drive enable |
| cntl_out | output | 6 | Control outputs (serial clock/data on bits 5/4 in serial-display mode) |
| rw_out | output | 1 | Read (1) or write (0) indication |
| wclk0 | output | 1 | Word clock, channel 0; chip select in serial-display mode |
| wclk1 | output | 1 | Word clock, channel 1 |
| tx_en | output | 1 | Return serial bit valid |
| tx_dat | output | 1 | Return serial bit |
| err_cnt | output | 8 | Count of dropped illegal frames |

## Verification
Directed frames cover each channel for writes and reads with all-ones and all-zero read data. Serial-display frames are sent with both chip-select levels, and illegal frames are sent as well. This tells apart a swapped channel, a wrong pulse width and a lost mirror pin. A truncated frame followed by a full read shows whether partial frames leak through. Random sequences of mixed frame types check that each operation starts from the state the previous one left behind, such as a chip select held low or data held on the bus.

// File: rtl/disp_link_pkg.sv
// Shared frame types and field positions for the display-side link receiver.
// Assumes the fixed frame layout listed in the brief (type in the lowest bits).
package disp_link_pkg;
    typedef enum logic [1:0] {
        FT_WRITE = 2'd0,
        FT_READ  = 2'd1,
        FT_SPI   = 2'd2,
        FT_BAD   = 2'd3
    } frame_type_e;

    typedef enum logic [1:0] {
        MD_WR,
        MD_RD,
        MD_SPI
    } op_mode_e;

    localparam int TYPE_LSB = 0;
    localparam int CHAN_BIT = 2;
    localparam int CS_BIT   = 3;
    localparam int CNTL_LSB = 4;
endpackage

// File: rtl/disp_link_frame_rx.sv
// Frame collector: shifts FRAME_W bits in, LSB first, while rx_en is high.
// It raises frm_vld for one cycle when a full frame is held in frm.
// Assumes the bits of a frame arrive back to back; a gap restarts collection.
module disp_link_frame_rx #(
    parameter int FRAME_W = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_en,
    input  logic               rx_dat,
    output logic               frm_vld,
    output logic [FRAME_W-1:0] frm
);
    localparam int CNT_W = $clog2(FRAME_W);

    logic [CNT_W-1:0] bit_cnt;

    // Shift register and bit counter; a frame is complete at the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            frm     <= '0;
            frm_vld <= 1'b0;
        end else begin
            frm_vld <= 1'b0;
            if (rx_en) begin
                frm <= {rx_dat, frm[FRAME_W-1:1]};
                if (bit_cnt == CNT_W'(FRAME_W-1)) begin
                    bit_cnt <= '0;
                    frm_vld <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else begin
                bit_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/disp_link_tx_ser.sv
// Return serializer: after a one-cycle go pulse, it sends DP_W bits LSB first,
// one per cycle, with tx_en high. Assumes go only arrives while idle.
module disp_link_tx_ser #(
    parameter int DP_W = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [DP_W-1:0] data,
    output logic            busy,
    output logic            tx_dat
);
    localparam int CNT_W = $clog2(DP_W);

    logic [DP_W-1:0]  shreg;
    logic [CNT_W-1:0] cnt;

    // Load on go, then shift one bit per cycle until DP_W bits have gone out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
        end else if (go && !busy) begin
            shreg <= data;
            cnt   <= '0;
            busy  <= 1'b1;
        end else if (busy) begin
            shreg <= shreg >> 1;
            if (cnt == CNT_W'(DP_W-1)) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign tx_dat = busy & shreg[0];
endmodule

// File: rtl/disp_link_seq.sv
// Port sequencer: turns a decoded frame into parallel-port activity.
// Write: drive bus, wait a setup cycle, pulse the selected word clock low.
// Read: drive control, release the bus, idle one cycle, pulse low, capture
// dp_in at the rising edge and hand the value to the return serializer.
// Serial-display: drive data and chip select, pulse the regenerated serial
// clock low on its two mirror pins. Illegal types only bump err_cnt.
// Assumes frames that arrive while an operation is running can be dropped.
module disp_link_seq
    import disp_link_pkg::*;
#(
    parameter int DP_W    = 18,
    parameter int CNTL_W  = 6,
    parameter int FRAME_W = 28,
    parameter int WR_LOW  = 3,
    parameter int RD_LOW  = 4,
    parameter int SPI_LOW = 2,
    parameter int ERR_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_vld,
    input  logic [FRAME_W-1:0] frm,
    input  logic [DP_W-1:0]    dp_in,
    input  logic               tx_busy,
    output logic [DP_W-1:0]    dp_out,
    output logic               dp_oe,
    output logic [CNTL_W-1:0]  cntl_out,
    output logic               rw_out,
    output logic [1:0]         wclk,
    output logic               tx_go,
    output logic [DP_W-1:0]    cap,
    output logic [ERR_W-1:0]   err_cnt
);
    localparam int DP_LSB  = CNTL_LSB + CNTL_W;
    localparam int MAX_LOW = (WR_LOW > RD_LOW) ? ((WR_LOW > SPI_LOW) ? WR_LOW : SPI_LOW)
                                               : ((RD_LOW > SPI_LOW) ? RD_LOW : SPI_LOW);
    localparam int LCNT_W  = $clog2(MAX_LOW + 1);
    localparam int SCLK_B  = 5;   // serial clock control bit
    localparam int SDAT_B  = 4;   // serial data control bit
    localparam int DP_SCLK = 6;   // serial clock mirror on the data bus
    localparam int DP_SDAT = 7;   // serial data mirror on the data bus

    typedef enum logic [1:0] { S_IDLE, S_SETUP, S_LOW, S_TXW } state_e;

    state_e             state;
    op_mode_e           mode;
    logic               sel;
    logic [LCNT_W-1:0]  lcnt;
    logic [LCNT_W-1:0]  lim;

    frame_type_e        f_type;
    logic               f_chan;
    logic               f_cs;
    logic [CNTL_W-1:0]  f_cntl;
    logic [DP_W-1:0]    f_dp;

    // Field split of the held frame.
    always_comb begin
        f_type = frame_type_e'(frm[TYPE_LSB +: 2]);
        f_chan = frm[CHAN_BIT];
        f_cs   = frm[CS_BIT];
        f_cntl = frm[CNTL_LSB +: CNTL_W];
        f_dp   = frm[DP_LSB +: DP_W];
    end

    // Low-pulse length for the running operation.
    always_comb begin
        case (mode)
            MD_WR:   lim = LCNT_W'(WR_LOW);
            MD_RD:   lim = LCNT_W'(RD_LOW);
            default: lim = LCNT_W'(SPI_LOW);
        endcase
    end

    // Operation state machine and all registered port outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            mode     <= MD_WR;
            sel      <= 1'b0;
            lcnt     <= '0;
            dp_out   <= '0;
            dp_oe    <= 1'b0;
            cntl_out <= '0;
            rw_out   <= 1'b0;
            wclk     <= 2'b11;
            tx_go    <= 1'b0;
            cap      <= '0;
            err_cnt  <= '0;
        end else begin
            tx_go <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (frm_vld) begin
                        case (f_type)
                            FT_WRITE: begin
                                mode     <= MD_WR;
                                sel      <= f_chan;
                                dp_out   <= f_dp;
                                cntl_out <= f_cntl;
                                rw_out   <= 1'b0;
                                dp_oe    <= 1'b1;
                                wclk     <= 2'b11;
                                state    <= S_SETUP;
                            end
                            FT_READ: begin
                                mode     <= MD_RD;
                                sel      <= f_chan;
                                cntl_out <= f_cntl;
                                rw_out   <= 1'b1;
                                dp_oe    <= 1'b0;
                                wclk     <= 2'b11;
                                state    <= S_SETUP;
                            end
                            FT_SPI: begin
                                mode             <= MD_SPI;
                                cntl_out         <= f_cntl;
                                cntl_out[SCLK_B] <= 1'b1;
                                dp_out[DP_SCLK]  <= 1'b1;
                                dp_out[DP_SDAT]  <= f_cntl[SDAT_B];
                                rw_out           <= 1'b0;
                                dp_oe            <= 1'b1;
                                wclk             <= {1'b1, f_cs};
                                state            <= S_SETUP;
                            end
                            default: begin
                                err_cnt <= err_cnt + 1'b1;
                            end
                        endcase
                    end
                end
                S_SETUP: begin
                    lcnt  <= '0;
                    state <= S_LOW;
                    if (mode == MD_SPI) begin
                        cntl_out[SCLK_B] <= 1'b0;
                        dp_out[DP_SCLK]  <= 1'b0;
                    end else begin
                        wclk[sel] <= 1'b0;
                    end
                end
                S_LOW: begin
                    if (lcnt == lim - 1'b1) begin
                        if (mode == MD_SPI) begin
                            cntl_out[SCLK_B] <= 1'b1;
                            dp_out[DP_SCLK]  <= 1'b1;
                            state            <= S_IDLE;
                        end else begin
                            wclk[sel] <= 1'b1;
                            if (mode == MD_RD) begin
                                cap   <= dp_in;
                                tx_go <= 1'b1;
                                state <= S_TXW;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end else begin
                        lcnt <= lcnt + 1'b1;
                    end
                end
                default: begin
                    if (!tx_go && !tx_busy) begin
                        state <= S_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/disp_link_slave.sv
// Top of the display-side link receiver: frame collector, port sequencer
// and return serializer. Assumes one clock domain for link and port.
module disp_link_slave #(
    parameter int DP_W    = 18,
    parameter int CNTL_W  = 6,
    parameter int WR_LOW  = 3,
    parameter int RD_LOW  = 4,
    parameter int SPI_LOW = 2,
    parameter int ERR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_dat,
    input  logic [DP_W-1:0]   dp_in,
    output logic [DP_W-1:0]   dp_out,
    output logic              dp_oe,
    output logic [CNTL_W-1:0] cntl_out,
    output logic              rw_out,
    output logic              wclk0,
    output logic              wclk1,
    output logic              tx_en,
    output logic              tx_dat,
    output logic [ERR_W-1:0]  err_cnt
);
    localparam int FRAME_W = 4 + CNTL_W + DP_W;

    logic               frm_vld;
    logic [FRAME_W-1:0] frm;
    logic [1:0]         wclk;
    logic               tx_go;
    logic               tx_busy;
    logic [DP_W-1:0]    cap;

    disp_link_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_dat(rx_dat),
        .frm_vld(frm_vld), .frm(frm)
    );

    disp_link_seq #(
        .DP_W(DP_W), .CNTL_W(CNTL_W), .FRAME_W(FRAME_W),
        .WR_LOW(WR_LOW), .RD_LOW(RD_LOW), .SPI_LOW(SPI_LOW), .ERR_W(ERR_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm(frm),
        .dp_in(dp_in), .tx_busy(tx_busy), .dp_out(dp_out), .dp_oe(dp_oe),
        .cntl_out(cntl_out), .rw_out(rw_out), .wclk(wclk), .tx_go(tx_go),
        .cap(cap), .err_cnt(err_cnt)
    );

    disp_link_tx_ser #(.DP_W(DP_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .go(tx_go), .data(cap),
        .busy(tx_busy), .tx_dat(tx_dat)
    );

    assign wclk0 = wclk[0];
    assign wclk1 = wclk[1];
    assign tx_en = tx_busy;
endmodule

// File: rtl/disp_link_slave_chk.sv
// Port-level property checker for disp_link_slave, attached by bind.
module disp_link_slave_chk #(
    parameter int DP_W   = 18,
    parameter int CNTL_W = 6,
    parameter int ERR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DP_W-1:0]   dp_out,
    input logic              dp_oe,
    input logic [CNTL_W-1:0] cntl_out,
    input logic              rw_out,
    input logic              wclk0,
    input logic              wclk1,
    input logic              tx_en,
    input logic [ERR_W-1:0]  err_cnt
);
    // Never both word clocks low at once (R3, R4, R6).
    p_one_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wclk0 && !wclk1));

    // Bus and control held while channel 1 clock is low (R3).
    p_hold_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wclk1 |-> ($stable(cntl_out) && $stable(dp_out) && $stable(dp_oe)));

    // Read pulse only after the bus was released for a cycle (R4).
    p_read_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_out && (!wclk0 || !wclk1)) |-> (!dp_oe && $past(!dp_oe)));

    // Return transfer runs with clocks idle and bus released (R5).
    p_tx_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (wclk0 && wclk1 && !dp_oe));

    // Error count moves only by single steps (R7).
    p_err_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + 1'b1));
endmodule

bind disp_link_slave disp_link_slave_chk #(.DP_W(DP_W), .CNTL_W(CNTL_W), .ERR_W(ERR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dp_out(dp_out), .dp_oe(dp_oe),
    .cntl_out(cntl_out), .rw_out(rw_out), .wclk0(wclk0), .wclk1(wclk1),
    .tx_en(tx_en), .err_cnt(err_cnt)
);

// File: tb/tb_disp_link_slave.sv
`timescale 1ns/1ps
module tb_disp_link_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        rx_dat = 1'b0;
    logic [17:0] dp_in = '0;
    logic [17:0] dp_out;
    logic        dp_oe;
    logic [5:0]  cntl_out;
    logic        rw_out;
    logic        wclk0;
    logic        wclk1;
    logic        tx_en;
    logic        tx_dat;
    logic [7:0]  err_cnt;

    int checks = 0;
    int errors = 0;
    int unsigned seed_val;

    always #2.5 clk = ~clk;

    disp_link_slave dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_dat(rx_dat), .dp_in(dp_in),
        .dp_out(dp_out), .dp_oe(dp_oe), .cntl_out(cntl_out), .rw_out(rw_out),
        .wclk0(wclk0), .wclk1(wclk1), .tx_en(tx_en), .tx_dat(tx_dat), .err_cnt(err_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Frame layout of R2.
    function automatic logic [27:0] mk_frame(input int t, input bit ch, input bit cs,
                                             input logic [5:0] c, input logic [17:0] d);
        return {d, c, cs, ch, 2'(t)};
    endfunction

    task automatic send_bits(input logic [27:0] f, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            rx_en  = 1'b1;
            rx_dat = f[i];
        end
        @(negedge clk);
        rx_en  = 1'b0;
        rx_dat = 1'b0;
    endtask

    // Send one full frame and check the port activity it causes.
    task automatic run_frame(input int t, input bit ch, input bit cs,
                             input logic [5:0] c, input logic [17:0] d,
                             input logic [17:0] rv);
        logic [17:0] p_dp, s_dp;
        logic [5:0]  p_c, s_c;
        logic        p_rw, p_oe, s_w0, s_w1;
        logic [7:0]  s_err;
        logic [17:0] txv = '0;
        int low_n = 0, tx_n = 0, exp_low;
        bit other_low = 0, stb;
        s_dp = dp_out; s_c = cntl_out; s_w0 = wclk0; s_w1 = wclk1; s_err = err_cnt;
        send_bits(mk_frame(t, ch, cs, c, d), 28);
        p_dp = dp_out; p_c = cntl_out; p_rw = rw_out; p_oe = dp_oe;
        exp_low = (t == 0) ? 3 : (t == 1) ? 4 : (t == 2) ? 2 : 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            stb = (t == 2) ? cntl_out[5] : (ch ? wclk1 : wclk0);
            if (t == 3) stb = 1'b1;
            if (!stb) begin
                low_n++;
                if (low_n == 1) begin
                    if (t == 0) begin
                        chk(p_dp == d && dp_out == d, "R3", "data before fall", dp_out, d);
                        chk(p_c == c && cntl_out == c, "R3", "control before fall", cntl_out, c);
                        chk(!p_rw && p_oe && dp_oe, "R3", "rw/oe before fall", {p_rw, p_oe}, 2'b01);
                    end else if (t == 1) begin
                        chk(p_c == c && cntl_out == c, "R4", "control before fall", cntl_out, c);
                        chk(p_rw && !p_oe && !dp_oe, "R4", "rw/oe before fall", {p_rw, p_oe}, 2'b10);
                        dp_in = rv;
                    end else begin
                        chk(dp_out[7] == c[4] && cntl_out[4] == c[4] && p_dp[7] == c[4],
                            "R6", "sdat mirrors", {dp_out[7], cntl_out[4]}, {c[4], c[4]});
                        chk(dp_out[6] == 1'b0 && p_dp[6] && p_c[5], "R6", "sclk mirror fall",
                            {p_dp[6], dp_out[6]}, 2'b10);
                        chk(wclk0 == cs && cntl_out[3:0] == c[3:0], "R6", "cs and control",
                            {wclk0, cntl_out[3:0]}, {cs, c[3:0]});
                    end
                end
            end
            if (t == 2) begin
                if (!wclk1) other_low = 1;
                if (cntl_out[5] != dp_out[6]) other_low = 1;
            end else if (ch ? !wclk0 : !wclk1) other_low = 1;
            if (tx_en && tx_n < 18) begin
                txv[tx_n] = tx_dat;
                tx_n++;
            end
            p_dp = dp_out; p_c = cntl_out; p_rw = rw_out; p_oe = dp_oe;
        end
        dp_in = '0;
        if (t == 0) chk(low_n == exp_low && !other_low, "R3", "pulse width/other clock", low_n, exp_low);
        if (t == 1) begin
            chk(low_n == exp_low && !other_low, "R4", "pulse width/other clock", low_n, exp_low);
            chk(tx_n == 18 && txv == rv, "R5", "returned data", txv, rv);
        end else begin
            chk(tx_n == 0, "R5", "no return transfer", tx_n, 0);
        end
        if (t == 2) begin
            chk(low_n == exp_low && !other_low, "R6", "sclk width/mirror/wclk1", low_n, exp_low);
            chk(wclk0 == cs && cntl_out[5] && dp_out[6], "R6", "cs held, sclk idle",
                {wclk0, cntl_out[5], dp_out[6]}, {cs, 2'b11});
        end
        if (t == 3) begin
            chk(err_cnt == s_err + 8'd1, "R7", "error count", err_cnt, s_err + 8'd1);
            chk(dp_out == s_dp && cntl_out == s_c && wclk0 == s_w0 && wclk1 == s_w1,
                "R7", "outputs unchanged", {dp_out, cntl_out}, {s_dp, s_c});
        end else begin
            chk(err_cnt == s_err, "R7", "error count still", err_cnt, s_err);
        end
        if (t == 0) chk(dp_out == d && cntl_out == c && !rw_out, "R8", "write values held",
                        {dp_out, cntl_out}, {d, c});
        if (t == 1) chk(dp_out == s_dp && cntl_out == c && rw_out, "R8", "read keeps bus value",
                        {dp_out, cntl_out}, {s_dp, c});
    endtask

    initial begin
        seed_val = $urandom(32'h1357);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wclk0 && wclk1 && !dp_oe && !tx_en, "R1", "reset clocks/oe/tx",
            {wclk0, wclk1, dp_oe, tx_en}, 4'b1100);
        chk(dp_out == 0 && cntl_out == 0 && !rw_out && err_cnt == 0, "R1", "reset values",
            {dp_out, cntl_out, rw_out, err_cnt}, 0);

        run_frame(0, 0, 1, 6'h2A, 18'h2_5A5A, 0);
        run_frame(0, 1, 1, 6'h15, 18'h1_3C3C, 0);
        run_frame(1, 0, 1, 6'h3F, 18'h0, 18'h3_FFFF);
        run_frame(1, 1, 1, 6'h01, 18'h0, 18'h0);
        run_frame(2, 0, 0, 6'h10, 18'h0, 0);
        run_frame(2, 0, 1, 6'h0F, 18'h0, 0);
        run_frame(3, 1, 0, 6'h33, 18'h1_1111, 0);
        run_frame(3, 0, 1, 6'h0C, 18'h2_2222, 0);
        // R2: truncated write, then a full read must act alone.
        send_bits(mk_frame(0, 1, 1, 6'h3F, 18'h3_FFFF), 12);
        repeat (4) @(negedge clk);
        chk(wclk1 && dp_out != 18'h3_FFFF, "R2", "partial frame discarded", dp_out, 0);
        run_frame(1, 0, 1, 6'h22, 18'h0, 18'h2_AAAA);

        for (int n = 0; n < 40; n++) begin
            int t = $urandom_range(3, 0);
            run_frame(t, 1'($urandom), 1'($urandom), 6'($urandom), 18'($urandom), 18'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule